// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives characters from an idle-high asynchronous serial line. The line runs through a two-flop synchroniser. A falling edge opens a character. The receiver counts 16, 32 or 64 of its own clocks per bit, as set by a 2-bit divisor code. It confirms the start bit half a bit after the edge, then samples each data bit and the optional parity bit at mid-bit. Finally it takes one sample at the middle of the stop bit.

Each finished character goes into a four-entry FIFO together with its own framing-error and parity-error flags, so a status bit always belongs to the character it describes. The consumer sees the oldest entry on a show-ahead read port and removes it with a one-cycle read strobe. When a character arrives while the FIFO is full, that character is dropped and a sticky overrun flag is raised.

Top module: `oversampled_rx`

## Requirements
- R1: `div_sel` selects clocks per bit: 00 gives 16, 01 gives 32, 10 gives 64. The reserved code 11 behaves as 10.
- R2: The line idles at 1 and passes through two synchroniser flops. A 1-to-0 transition of the synchronised line starts a character. Eight data bits follow, least significant first, each sampled at its midpoint.
- R3: Half a bit time after the detected edge the line is sampled again. If it reads 1, the start is a glitch, no character is produced and the receiver returns to idle.
- R4: With `par_en`=1 a parity bit follows the data. `par_odd`=0 selects even parity, meaning the nine bits carry an even number of ones; `par_odd`=1 selects odd parity. A mismatch sets that character's parity-error flag. With `par_en`=0 there is no parity bit and the flag reads 0.
- R5: The stop bit is sampled exactly once, at the midpoint of a one-bit stop. A 0 there sets the character's framing-error flag. The stop length is not checked in any other way.
- R6: The receiver accepts a new start edge right after the stop sample. Back-to-back characters whose stop bits last only about 0.7 bit time are all received.
- R7: The FIFO holds 4 entries and returns them oldest first. `rd_valid` is 1 while the FIFO is not empty. `rd_data`, `rd_frame_err` and `rd_par_err` show the head entry. `rd_en`=1 while `rd_valid`=1 removes the head at the clock edge.
- R8: A character that completes while the FIFO holds 4 entries, with no pop in the same cycle, is discarded and leaves the stored entries intact. It sets `overrun`, which stays 1 until reset.
- R9: After synchronous reset, `rd_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, oversampling reference |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| div_sel | input | 2 | Oversampling code (16/32/64 clocks per bit) |
| par_en | input | 1 | Parity bit expected after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Remove the head entry |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rd_data | output | 8 | Head character |
| rd_frame_err | output | 1 | Head character's stop sample was 0 |
| rd_par_err | output | 1 | Head character's parity mismatched |
| overrun | output | 1 | Sticky: a character was lost to a full FIFO |

## Verification
The hardest case to reach is a new start edge that arrives only a few cycles after the stop-bit sample, while the FIFO is also near its limit. The bench gets there by driving characters whose stop level lasts half a bit plus three clocks and starting the next start bit at once. It also holds off reads across five characters, one of them carrying a framing error, so that the overrun lands on a full FIFO and the error flag has to survive the trip through the FIFO. Start glitches shorter than half a bit are driven at two divisor settings, each followed by a clean character.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned BASE_OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/osrx_framer.sv
module osrx_framer
  import osrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_s,
  input  logic [1:0] div_sel,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int unsigned CNT_W  = $clog2(BASE_OVS * 4);
  localparam int unsigned BIT_W  = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] FULL16 = CNT_W'(BASE_OVS - 1);
  localparam logic [CNT_W-1:0] FULL32 = CNT_W'(BASE_OVS * 2 - 1);
  localparam logic [CNT_W-1:0] FULL64 = CNT_W'(BASE_OVS * 4 - 1);
  localparam logic [CNT_W-1:0] HALF16 = CNT_W'(BASE_OVS / 2 - 1);
  localparam logic [CNT_W-1:0] HALF32 = CNT_W'(BASE_OVS - 1);
  localparam logic [CNT_W-1:0] HALF64 = CNT_W'(BASE_OVS * 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

  rx_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bitn_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              par_acc_q;
  logic              pe_q;
  logic              line_d;
  logic              fall;
  logic [CNT_W-1:0]  full_lim;
  logic [CNT_W-1:0]  half_lim;

  // code 11 is reserved and runs like 10
  always_comb begin
    case (div_sel)
      2'b00:   begin full_lim = FULL16; half_lim = HALF16; end
      2'b01:   begin full_lim = FULL32; half_lim = HALF32; end
      default: begin full_lim = FULL64; half_lim = HALF64; end
    endcase
  end

  assign fall = line_d & ~line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      pe_q      <= 1'b0;
      line_d    <= 1'b1;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      line_d <= line_s;
      push_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall) state_q <= ST_START;
        end
        ST_START: begin
          if (cnt_q == half_lim) begin
            cnt_q <= '0;
            if (line_s) begin
              state_q <= ST_IDLE;
            end else begin
              state_q   <= ST_DATA;
              bitn_q    <= '0;
              par_acc_q <= par_odd;
              pe_q      <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == full_lim) begin
            cnt_q     <= '0;
            shreg_q   <= {line_s, shreg_q[CHAR_W-1:1]};
            par_acc_q <= par_acc_q ^ line_s;
            if (bitn_q == LAST_BIT) state_q <= par_en ? ST_PAR : ST_STOP;
            else                    bitn_q  <= bitn_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == full_lim) begin
            cnt_q   <= '0;
            pe_q    <= par_acc_q ^ line_s;
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == full_lim) begin
            cnt_q        <= '0;
            push_o       <= 1'b1;
            entry_o.fe   <= ~line_s;
            entry_o.pe   <= pe_q;
            entry_o.data <= shreg_q;
            state_q      <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: only a falling edge leaves idle
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !fall) |=> state_q == ST_IDLE);

  // R3: a high line at the half-bit check abandons the character
  assert_glitch_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && cnt_q == half_lim && line_s) |=> (state_q == ST_IDLE && !push_o));

  // R5: a character is handed on only after the stop sample
  assert_push_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(state_q == ST_STOP));

  // R6: after handing on a character the receiver is back in idle
  assert_ready_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    push_o |-> state_q == ST_IDLE);
endmodule

// File: rtl/osrx_fifo.sv
module osrx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         rd_en,
  output logic         valid,
  output logic [W-1:0] head,
  output logic         overrun
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   count_q;
  logic          full, pop, accept;

  assign full   = (count_q == FULL_CNT);
  assign pop    = rd_en && (count_q != '0);
  assign accept = push && (!full || pop);

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (pop)    rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
      case ({accept, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push && !accept) overrun <= 1'b1;
    end
  end

  assign valid = (count_q != '0);
  assign head  = mem[rptr_q];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full && !rd_en) |=> (overrun && count_q == FULL_CNT));
endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx
  import osrx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic [1:0]        div_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_frame_err,
  output logic              rd_par_err,
  output logic              overrun
);
  localparam int unsigned ENTRY_W = $bits(rx_entry_t);

  logic      line_s;
  logic      push;
  rx_entry_t entry_in, entry_out;

  osrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(line_s)
  );

  osrx_framer u_framer (
    .clk(clk), .rst(rst), .line_s(line_s), .div_sel(div_sel),
    .par_en(par_en), .par_odd(par_odd), .push_o(push), .entry_o(entry_in)
  );

  osrx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(entry_in), .rd_en(rd_en),
    .valid(rd_valid), .head(entry_out), .overrun(overrun)
  );

  assign rd_data      = entry_out.data;
  assign rd_frame_err = entry_out.fe;
  assign rd_par_err   = entry_out.pe;

  // R9: nothing is readable in the first cycle after reset
  assert_reset_empty_R9: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && !overrun));
endmodule

// File: tb/tb_oversampled_rx.sv
module tb_oversampled_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic [1:0] div_sel = 2'b00;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_frame_err, rd_par_err, overrun;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oversampled_rx dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .div_sel(div_sel),
    .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_frame_err(rd_frame_err),
    .rd_par_err(rd_par_err), .overrun(overrun)
  );

  function automatic int bit_len(input logic [1:0] code);
    return (code == 2'b00) ? 16 : (code == 2'b01) ? 32 : 64;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit flip_par,
                           input logic stop_v, input int stop_cycles);
    int n;
    logic p;
    n = bit_len(div_sel);
    hold(1'b0, n);
    for (int i = 0; i < 8; i++) hold(d[i], n);
    if (par_en) begin
      p = par_odd ? ~^d : ^d;
      hold(p ^ flip_par, n);
    end
    hold(stop_v, stop_cycles);
    rx_in = 1'b1;
  endtask

  task automatic expect_char(input logic [7:0] d, input logic fe, input logic pe,
                             input string tag);
    int waited;
    waited = 0;
    while (!rd_valid && waited < 1500) begin
      @(negedge clk);
      waited++;
    end
    chk(rd_valid, {tag, " valid"}, rd_valid, 1);
    if (rd_valid) begin
      chk(rd_data == d, {tag, " data"}, rd_data, d);
      chk(rd_frame_err == fe, {tag, " frame_err"}, rd_frame_err, fe);
      chk(rd_par_err == pe, {tag, " par_err"}, rd_par_err, pe);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] pat [5];
    logic [7:0] ov [5];
    int n;
    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h3C; pat[4] = 8'h01;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!rd_valid, "R9 rd_valid after reset", rd_valid, 0);
    chk(!overrun, "R9 overrun after reset", overrun, 0);

    // R1 R2 R4: sweep divisor codes (incl. reserved 11), parity modes, patterns
    for (int dv = 0; dv < 4; dv++) begin
      div_sel = 2'(dv);
      for (int pm = 0; pm < 3; pm++) begin
        par_en  = (pm != 0);
        par_odd = (pm == 2);
        for (int k = 0; k < 5; k++) begin
          send_char(pat[k], 1'b0, 1'b1, bit_len(div_sel));
          expect_char(pat[k], 1'b0, 1'b0, "R1 R2 R4 sweep");
        end
        if (par_en) begin
          // R4: corrupted parity bit
          send_char(8'h5A ^ 8'(dv), 1'b1, 1'b1, bit_len(div_sel));
          expect_char(8'h5A ^ 8'(dv), 1'b0, 1'b1, "R4 parity mismatch");
        end
      end
    end

    div_sel = 2'b00; par_en = 1'b0; par_odd = 1'b0;
    n = 16;

    // R5: stop sample low gives framing error; line then recovers
    send_char(8'hC3, 1'b0, 1'b0, n);
    hold(1'b1, 2 * n);
    expect_char(8'hC3, 1'b1, 1'b0, "R5 framing error");

    // R3: short start glitch at 16x, then a clean character
    hold(1'b0, 3);
    hold(1'b1, 3 * n);
    chk(!rd_valid, "R3 glitch ignored 16x", rd_valid, 0);
    send_char(8'h96, 1'b0, 1'b1, n);
    expect_char(8'h96, 1'b0, 1'b0, "R3 after glitch 16x");

    // R3: glitch of 20 clocks at 64x
    div_sel = 2'b10;
    hold(1'b0, 20);
    hold(1'b1, 3 * 64);
    chk(!rd_valid, "R3 glitch ignored 64x", rd_valid, 0);
    send_char(8'h69, 1'b0, 1'b1, 64);
    expect_char(8'h69, 1'b0, 1'b0, "R3 after glitch 64x");

    // R6 R7: back-to-back characters with shortened stop bits, with parity
    div_sel = 2'b00; par_en = 1'b1; par_odd = 1'b1;
    send_char(8'h11, 1'b0, 1'b1, n / 2 + 3);
    send_char(8'hEE, 1'b0, 1'b1, n / 2 + 3);
    send_char(8'h7E, 1'b0, 1'b1, n);
    expect_char(8'h11, 1'b0, 1'b0, "R6 short stop first");
    expect_char(8'hEE, 1'b0, 1'b0, "R6 short stop second");
    expect_char(8'h7E, 1'b0, 1'b0, "R6 R7 order third");
    chk(!overrun, "R8 no overrun yet", overrun, 0);

    // R7 R8: five characters without reading; second has a framing error
    par_en = 1'b0;
    ov[0] = 8'h21; ov[1] = 8'h42; ov[2] = 8'h84; ov[3] = 8'h18; ov[4] = 8'hF0;
    for (int k = 0; k < 5; k++) begin
      send_char(ov[k], 1'b0, (k == 1) ? 1'b0 : 1'b1, n);
      hold(1'b1, n);
    end
    chk(overrun, "R8 overrun set on full write", overrun, 1);
    for (int k = 0; k < 4; k++)
      expect_char(ov[k], (k == 1), 1'b0, "R7 R8 fifo content");
    @(negedge clk);
    chk(!rd_valid, "R8 discarded fifth character", rd_valid, 0);
    chk(overrun, "R8 overrun sticky after reads", overrun, 1);
    send_char(8'hBD, 1'b0, 1'b1, n);
    expect_char(8'hBD, 1'b0, 1'b0, "R7 accepts after drain");
    chk(overrun, "R8 overrun sticky after new char", overrun, 1);

    // R9: reset clears the sticky flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!overrun, "R9 overrun cleared", overrun, 0);
    chk(!rd_valid, "R9 fifo empty", rd_valid, 0);

    finish_run();
  end
endmodule